// File: doc/BRIEF.md
# Link Wake-Up and Idle Controller

This block sequences the power state of one end of an isolated, pulse-signalled SPI link. It moves between three states: IDLE (bias off, low power), READY (bias on, analog front end settling) and ACTIVE (traffic allowed). It drives the bias-enable request for the line front end. It also holds the local SPI outputs at their quiet levels while the link sleeps.

In slave role the block watches a digital line-detect input, which the external comparator raises when the differential line level exceeds its threshold. A wake is accepted only if that input stays high for a minimum run of clock cycles. In master role the line detect is not used. A falling edge on the host chip select wakes the block, and on leaving READY it asks the line driver for one long pulse. The pulse polarity copies the chip-select level at that moment. Once ACTIVE, an inactivity timer returns the block to IDLE. Line activity (slave) or a low or toggling chip select (master) restarts that timer. A stay-awake input turns the idle feature off in both roles. All durations are parameters in clock cycles, derived by default from a clock-frequency parameter.

Named transitions: WAKE (IDLE to READY), SETTLED (READY to ACTIVE), TIMEOUT (ACTIVE to IDLE).

Top module: `link_power_seq`

## Requirements
- R1: After reset the block is in IDLE: `state_o` = 2'b00, `bias_en` = 0, `link_ready` = 0, `wake_pulse` = 0 and `tx_stb` = 0. State codes are 2'b00 IDLE, 2'b01 READY and 2'b10 ACTIVE. `bias_en` is 1 exactly in READY and ACTIVE, and `link_ready` is 1 exactly in ACTIVE.
- R2: In slave role (`role_master` = 0) in IDLE, if `line_detect` is high on FILT_CYC consecutive rising edges, the block is in READY after the next edge, and `wake_pulse` is 1 for exactly that first READY cycle.
- R3: In slave role, a `line_detect` run shorter than FILT_CYC edges causes no wake. A single low edge restarts the run count, so two short runs separated by a low cycle do not add up.
- R4: READY lasts exactly SETTLE_CYC cycles and is always followed by ACTIVE. IDLE never goes straight to ACTIVE.
- R5: In slave role in ACTIVE with `stay_awake` = 0, the block returns to IDLE IDLE_CYC edges after the last edge that sampled `line_detect` high (or after entering ACTIVE). Every high sample restarts this count.
- R6: In slave role while in IDLE, `spi_cs` = 1, `spi_mosi` = 1 and `spi_sck` = `sck_pol`. In any other state, and always in master role, these outputs pass `dec_cs`, `dec_mosi` and `dec_sck` through unchanged.
- R7: In master role, `line_detect` has no effect in IDLE. A falling edge of `cs_in` sampled in IDLE moves the block to READY with a one-cycle `wake_pulse`.
- R8: In master role, the first ACTIVE cycle carries `tx_stb` = 1 with `tx_pol` equal to the `cs_in` level sampled on the SETTLED edge (1 = positive pulse). If that level was 0, the first rising `cs_in` in ACTIVE gives one more one-cycle `tx_stb` with `tx_pol` = 1. No other strobes occur.
- R9: In master role, ACTIVE holds while `cs_in` is low. After `cs_in` goes high and stays high, with `stay_awake` = 0, the block is in IDLE IDLE_CYC edges after the rising edge.
- R10: With `stay_awake` = 1, the block leaves IDLE on the next edge with a `wake_pulse`, in either role, and does not return to IDLE from READY or ACTIVE. After `stay_awake` drops, the idle count starts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| role_master | input | 1 | 1 = master role, 0 = slave role (static configuration) |
| stay_awake | input | 1 | 1 disables the idle feature and forces a wake |
| sck_pol | input | 1 | Configured idle level of the local SPI clock |
| line_detect | input | 1 | Comparator output: differential line level above threshold |
| cs_in | input | 1 | Host chip select (master role), active low |
| dec_cs | input | 1 | Chip select decoded from the line |
| dec_mosi | input | 1 | Data decoded from the line |
| dec_sck | input | 1 | Clock decoded from the line |
| spi_cs | output | 1 | Local SPI chip select |
| spi_mosi | output | 1 | Local SPI data out |
| spi_sck | output | 1 | Local SPI clock |
| bias_en | output | 1 | Bias enable for the line front end |
| link_ready | output | 1 | Traffic allowed (ACTIVE) |
| state_o | output | 2 | Current state code |
| wake_pulse | output | 1 | One-cycle marker of each WAKE transition |
| tx_stb | output | 1 | One-cycle request to send a long line pulse |
| tx_pol | output | 1 | Polarity of the requested long pulse (1 = positive) |

## Verification
The bench probes the persistence filter right at its edge. A run of FILT_CYC-1 high samples must be rejected, an interrupted pair of short runs must not add up, and a run of exactly FILT_CYC must be accepted. A filter that is off by one would wake on noise or miss a genuine wake. Settle and idle windows are checked one cycle before and on the expected edge, so a counter that stops one count early or late shows up as a premature or late state change. A timer that ignores restarts would time out during traffic. In master role the bench checks both cases of the long pulse: a chip select still low when settling ends, which must give a negative pulse followed by exactly one positive pulse, and a chip select already released, which must give a single positive pulse. It also confirms that line activity cannot wake a master.

// File: rtl/lps_pkg.sv
package lps_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_READY  = 2'b01,
        ST_ACTIVE = 2'b10
    } lps_state_e;

endpackage

// File: rtl/lps_wake_filter.sv
// Persistence filter: qual_o is high once line_i has been sampled high on
// RUN_CYC consecutive edges; any low sample clears the run.
module lps_wake_filter #(
    parameter int RUN_CYC = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic qual_o
);
    localparam int CW = $clog2(RUN_CYC + 1);
    localparam logic [CW-1:0] FULL = CW'(RUN_CYC);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!line_i) begin
            run_q <= '0;
        end else if (run_q != FULL) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign qual_o = (run_q == FULL);

endmodule

// File: rtl/lps_span_timer.sv
// Saturating interval counter: done_o rises after SPAN_CYC-1 run cycles
// following a clear, so a state guarded by it lasts SPAN_CYC cycles.
module lps_span_timer #(
    parameter int SPAN_CYC = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = (SPAN_CYC > 2) ? $clog2(SPAN_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(SPAN_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (run_i && !done_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = (cnt_q == LAST);

endmodule

// File: rtl/link_power_seq.sv
module link_power_seq
    import lps_pkg::*;
#(
    parameter int CLK_MHZ    = 250,
    parameter int FILT_CYC   = (CLK_MHZ * 240) / 1000,
    parameter int SETTLE_CYC = CLK_MHZ * 8,
    parameter int IDLE_CYC   = CLK_MHZ * 5700
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       role_master,
    input  logic       stay_awake,
    input  logic       sck_pol,
    input  logic       line_detect,
    input  logic       cs_in,
    input  logic       dec_cs,
    input  logic       dec_mosi,
    input  logic       dec_sck,
    output logic       spi_cs,
    output logic       spi_mosi,
    output logic       spi_sck,
    output logic       bias_en,
    output logic       link_ready,
    output logic [1:0] state_o,
    output logic       wake_pulse,
    output logic       tx_stb,
    output logic       tx_pol
);
    lps_state_e state_q, state_d;

    logic cs_prev_q;
    logic cs_fall, cs_rise;
    logic line_qual;
    logic settle_done, idle_done;
    logic activity;
    logic wake_req;
    logic pend_pos_q;

    // Edge detection on the host chip select
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_prev_q <= 1'b1;
        else        cs_prev_q <= cs_in;
    end

    assign cs_fall = cs_prev_q && !cs_in;
    assign cs_rise = !cs_prev_q && cs_in;

    lps_wake_filter #(.RUN_CYC(FILT_CYC)) i_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (line_detect),
        .qual_o (line_qual)
    );

    assign wake_req = stay_awake || (role_master ? cs_fall : line_qual);
    assign activity = role_master ? (!cs_in || cs_fall || cs_rise) : line_detect;

    lps_span_timer #(.SPAN_CYC(SETTLE_CYC)) i_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (state_q != ST_READY),
        .run_i   (state_q == ST_READY),
        .done_o  (settle_done)
    );

    lps_span_timer #(.SPAN_CYC(IDLE_CYC)) i_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i ((state_q != ST_ACTIVE) || activity || stay_awake),
        .run_i   (state_q == ST_ACTIVE),
        .done_o  (idle_done)
    );

    // Next-state logic: WAKE, SETTLED, TIMEOUT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (wake_req)    state_d = ST_READY;
            ST_READY:  if (settle_done) state_d = ST_ACTIVE;
            ST_ACTIVE: if (!stay_awake && idle_done && !activity) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered event outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_pulse <= 1'b0;
            tx_stb     <= 1'b0;
            tx_pol     <= 1'b0;
            pend_pos_q <= 1'b0;
        end else begin
            wake_pulse <= (state_q == ST_IDLE) && (state_d == ST_READY);
            tx_stb     <= 1'b0;
            if (role_master && state_q == ST_READY && state_d == ST_ACTIVE) begin
                tx_stb     <= 1'b1;
                tx_pol     <= cs_in;
                pend_pos_q <= !cs_in;
            end else if (role_master && state_q == ST_ACTIVE && pend_pos_q && cs_rise) begin
                tx_stb     <= 1'b1;
                tx_pol     <= 1'b1;
                pend_pos_q <= 1'b0;
            end else if (state_q == ST_IDLE) begin
                pend_pos_q <= 1'b0;
            end
        end
    end

    // Level outputs
    always_comb begin
        bias_en    = (state_q != ST_IDLE);
        link_ready = (state_q == ST_ACTIVE);
        state_o    = state_q;
        if (!role_master && state_q == ST_IDLE) begin
            spi_cs   = 1'b1;
            spi_mosi = 1'b1;
            spi_sck  = sck_pol;
        end else begin
            spi_cs   = dec_cs;
            spi_mosi = dec_mosi;
            spi_sck  = dec_sck;
        end
    end

endmodule

// File: rtl/lps_checker.sv
module lps_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       role_master,
    input logic       stay_awake,
    input logic       cs_in,
    input logic [1:0] state_o,
    input logic       link_ready,
    input logic       wake_pulse,
    input logic       tx_stb
);
    AST_WAKE_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> (state_o == 2'b01 && $past(state_o) == 2'b00)); // R2

    AST_NO_SETTLE_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b00) |=> (state_o != 2'b10)); // R4

    AST_READY_BEFORE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_ready) |-> ($past(state_o) == 2'b01)); // R4

    AST_MASTER_CS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (role_master && !cs_in && state_o == 2'b10) |=> (state_o == 2'b10)); // R9

    AST_TX_MASTER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stb |-> (role_master && link_ready)); // R8

    AST_STAY_AWAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stay_awake && state_o != 2'b00) |=> (state_o != 2'b00)); // R10

endmodule

bind link_power_seq lps_checker i_lps_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .role_master (role_master),
    .stay_awake  (stay_awake),
    .cs_in       (cs_in),
    .state_o     (state_o),
    .link_ready  (link_ready),
    .wake_pulse  (wake_pulse),
    .tx_stb      (tx_stb)
);

// File: tb/test_link_power_seq.sv
`timescale 1ns/1ps
module test_link_power_seq;

    localparam int F = 6;
    localparam int S = 20;
    localparam int T = 100;

    logic clk = 1'b0;
    logic rst_n, role_master, stay_awake, sck_pol, line_detect, cs_in;
    logic dec_cs, dec_mosi, dec_sck;
    logic spi_cs, spi_mosi, spi_sck, bias_en, link_ready, wake_pulse, tx_stb, tx_pol;
    logic [1:0] state_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    link_power_seq #(.CLK_MHZ(250), .FILT_CYC(F), .SETTLE_CYC(S), .IDLE_CYC(T)) i_link_power_seq (
        .clk(clk), .rst_n(rst_n), .role_master(role_master), .stay_awake(stay_awake),
        .sck_pol(sck_pol), .line_detect(line_detect), .cs_in(cs_in),
        .dec_cs(dec_cs), .dec_mosi(dec_mosi), .dec_sck(dec_sck),
        .spi_cs(spi_cs), .spi_mosi(spi_mosi), .spi_sck(spi_sck),
        .bias_en(bias_en), .link_ready(link_ready), .state_o(state_o),
        .wake_pulse(wake_pulse), .tx_stb(tx_stb), .tx_pol(tx_pol)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected local SPI pins {cs, mosi, sck}
    function automatic logic [2:0] exp_pins(logic master, logic [1:0] st, logic pol,
                                            logic c, logic m, logic k);
        if (!master && st == 2'b00) return {1'b1, 1'b1, pol};
        return {c, m, k};
    endfunction

    function automatic logic [1:0] exp_after_run(int len);
        return (len >= F) ? 2'b01 : 2'b00;
    endfunction

    task automatic chk_pins(string req);
        chk(req, {spi_cs, spi_mosi, spi_sck},
            exp_pins(role_master, state_o, sck_pol, dec_cs, dec_mosi, dec_sck));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2718));
        rst_n = 0; role_master = 0; stay_awake = 0; sck_pol = 0;
        line_detect = 0; cs_in = 1; dec_cs = 0; dec_mosi = 0; dec_sck = 0;
        tick(3);
        rst_n = 1;
        tick(1);

        // R1 reset state
        chk("R1 state", state_o, 2'b00);
        chk("R1 bias", bias_en, 0);
        chk("R1 ready", link_ready, 0);
        chk("R1 wake", wake_pulse, 0);
        chk("R1 tx", tx_stb, 0);

        // R6 idle pin levels for both clock polarities
        sck_pol = 1; #1 chk_pins("R6 idle pol1");
        sck_pol = 0; #1 chk_pins("R6 idle pol0");

        // R3 one short of the filter, then interrupted runs
        line_detect = 1; tick(F - 1); line_detect = 0; tick(1);
        chk("R3 short run", state_o, 2'b00);
        line_detect = 1; tick(F - 1); line_detect = 0; tick(1);
        line_detect = 1; tick(F - 1); line_detect = 0; tick(1);
        chk("R3 split run", state_o, 2'b00);

        // R3/R2 random runs against the bench model
        for (int i = 0; i < 12; i++) begin
            int len;
            len = 1 + int'($urandom % (F + 1));
            {dec_cs, dec_mosi, dec_sck} = 3'($urandom);
            line_detect = 1; tick(len); line_detect = 0; tick(1);
            chk(len >= F ? "R2 random run" : "R3 random run", state_o, exp_after_run(len));
            chk_pins("R6 random");
            if (len >= F) begin
                tick(S + T + 5);
                chk("R5 return", state_o, 2'b00);
            end
            tick(1 + int'($urandom % 4));
        end

        // R2 exact-length wake
        line_detect = 1; tick(F); line_detect = 0; tick(1);
        chk("R2 state", state_o, 2'b01);
        chk("R2 wake pulse", wake_pulse, 1);
        chk("R1 bias ready", {bias_en, link_ready}, 2'b10);
        tick(1);
        chk("R2 pulse once", wake_pulse, 0);

        // R4 settle window
        tick(S - 2);
        chk("R4 still ready", state_o, 2'b01);
        tick(1);
        chk("R4 active", state_o, 2'b10);
        chk("R1 link ready", link_ready, 1);
        for (int i = 0; i < 4; i++) begin
            {dec_cs, dec_mosi, dec_sck} = 3'($urandom);
            #1 chk_pins("R6 pass");
        end

        // R5 activity restarts idle count
        for (int i = 0; i < 5; i++) begin
            tick(10 + int'($urandom % (T - 20)));
            chk("R5 held", state_o, 2'b10);
            line_detect = 1; tick(1); line_detect = 0;
        end
        tick(T - 1);
        chk("R5 before timeout", state_o, 2'b10);
        tick(1);
        chk("R5 timeout", state_o, 2'b00);
        sck_pol = 1; #1 chk_pins("R6 idle again");

        // R10 stay-awake in slave role
        stay_awake = 1; tick(1);
        chk("R10 wake", {state_o, wake_pulse}, {2'b01, 1'b1});
        tick(S - 1); chk("R10 ready", state_o, 2'b01);
        tick(1);     chk("R10 active", state_o, 2'b10);
        tick(3 * T); chk("R10 no idle", state_o, 2'b10);
        stay_awake = 0;
        tick(T - 1); chk("R10 count restarts", state_o, 2'b10);
        tick(1);     chk("R10 idle after release", state_o, 2'b00);

        // R7 master ignores line detect
        role_master = 1;
        {dec_cs, dec_mosi, dec_sck} = 3'b010;
        #1 chk_pins("R6 master idle pass");
        line_detect = 1; tick(2 * F); line_detect = 0; tick(1);
        chk("R7 line ignored", state_o, 2'b00);

        // R7/R8/R9 chip select held low through settling
        cs_in = 0; tick(1);
        chk("R7 wake", {state_o, wake_pulse}, {2'b01, 1'b1});
        tick(S - 1); chk("R7 ready", state_o, 2'b01);
        tick(1);
        chk("R8 neg pulse", {state_o, tx_stb, tx_pol}, {2'b10, 1'b1, 1'b0});
        tick(1);     chk("R8 single", tx_stb, 0);
        tick(3 * T); chk("R9 held low", state_o, 2'b10);
        chk("R8 no extra", tx_stb, 0);
        cs_in = 1; tick(1);
        chk("R8 pos pulse", {tx_stb, tx_pol}, 2'b11);
        tick(1);     chk("R8 pos once", tx_stb, 0);
        tick(T - 2); chk("R9 before timeout", state_o, 2'b10);
        tick(1);     chk("R9 timeout", state_o, 2'b00);

        // R8 chip select released during settling
        cs_in = 0; tick(1);
        chk("R7 wake again", state_o, 2'b01);
        cs_in = 1;
        tick(S - 1); chk("R8 ready", state_o, 2'b01);
        tick(1);
        chk("R8 pos only", {state_o, tx_stb, tx_pol}, {2'b10, 1'b1, 1'b1});
        tick(1);     chk("R8 no follow", tx_stb, 0);
        tick(T - 2); chk("R9 before idle", state_o, 2'b10);
        tick(1);     chk("R9 idle", state_o, 2'b00);

        finish_run();
    end

endmodule